// File: doc/BRIEF.md
# Cable Presence Power Allocator

This block watches one active-low presence line per auxiliary power connector. A line held low means a card is attached at the far end of the cable. A line that floats high means the cable is unused or not fully seated. Each line passes through a synchronizer and a stable-value debounce. The block then counts the attached cards and splits a fixed power budget across them. The result is a two-bit power-limit code per connector, which the pin drivers put onto that connector's sense pair.

Presence is sampled, and codes are computed, while the supply is still in standby, before the main 12 V output comes up. The code register loads a fresh value on every cycle of standby. It holds its contents from the edge at which the power-on request is asserted, and it keeps holding them while the main rails are reported good. The power-on request and the rails-good flag come from the supply's own sequencing logic, which runs on the same clock.

Top module: `cblp_alloc`

## Requirements
- R1: While reset is active, and directly after it, every connector's code is 2'b00.
- R2: A presence bit at 0 means a card is attached and 1 means the connector is empty. An empty connector always carries code 2'b00 (both sense lines open, 0 W).
- R3: With exactly one card attached, that connector carries 2'b11 (600 W).
- R4: With exactly two cards attached, both connectors carry 2'b10 (300 W).
- R5: With three or four cards attached, each attached connector carries 2'b01 (150 W).
- R6: With five or more cards attached, the four attached connectors with the lowest indices carry 2'b01. Every other attached connector carries 2'b00.
- R7: A presence level is accepted only after it has stayed unchanged for 16 consecutive cycles at the synchronizer output. A pulse of 15 cycles or less has no effect on any code.
- R8: Take a presence level applied before clock edge 0 and held, during standby. It shows on the codes after edge 18, and the codes still show the old value after edge 17.
- R9: While the power-on request is asserted (ps_on_n at 0), or while rails_good is 1, the codes do not change, whatever the presence lines do.
- R10: Once ps_on_n is 1 and rails_good is 0 again, the codes take the allocation for the current debounced presence at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pres_n | input | 8 | Presence lines, one per connector, low = card attached |
| ps_on_n | input | 1 | Power-on request, active low, synchronous to clk |
| rails_good | input | 1 | Main rails are up, synchronous to clk |
| sense_code | output | 16 | Two bits per connector, connector i at bits [2i+1:2i] |

## Verification
Three groups of corner cases get directed tests.

- **Allocation thresholds.** The bench covers the step from four cards to five. It also covers the case where the dropped connectors must be the highest-index ones, even when the attached ones are scattered. A design that counted wrongly, or ranked from the wrong end, would grant 150 W to the wrong connector or to more than four.
- **Debounce and latency.** A 15-cycle glitch must leave the codes alone. The exact cycle in which a held level reaches the output is also checked. A counter that is off by one, or a missing synchronizer stage, shows up as early or late codes.
- **Freeze interlock.** Presence changes while the supply is on must not reach the codes. This holds both with the request asserted and with the rails still good after it is released. The codes must then catch up in one edge when standby returns. A design that gated on only one of the two conditions would let the codes move under load.

// File: rtl/cblp_pkg.sv
package cblp_pkg;

  // Two-bit power-limit code driven onto a connector's sense pair
  typedef enum logic [1:0] {
    LVL_OFF = 2'b00,  // both sense lines open, 0 W
    LVL_150 = 2'b01,
    LVL_300 = 2'b10,
    LVL_600 = 2'b11
  } pwr_lvl_e;

  // Largest number of cards that can share the budget at the lowest tier
  localparam int SHARE_MAX = 4;

  function automatic pwr_lvl_e tier_for_count(input int unsigned cards);
    pwr_lvl_e t;
    if (cards == 0)      t = LVL_OFF;
    else if (cards == 1) t = LVL_600;
    else if (cards == 2) t = LVL_300;
    else                 t = LVL_150;
    return t;
  endfunction

endpackage

// File: rtl/cblp_deb.sv
// One presence line: synchronizer chain followed by a stable-value debounce.
module cblp_deb #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_n,
  output logic sync_n,
  output logic stable_n
);

  localparam int DEB_W = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
  localparam logic [DEB_W-1:0] CNT_LAST = DEB_W'(DEB_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sff_q;
  logic [DEB_W-1:0]       cnt_q, cnt_d;
  logic                   stab_q, stab_d;
  logic                   differ;

  // Synchronizer: reset to "absent"
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sff_q <= '1;
    else        sff_q <= {sff_q[SYNC_STAGES-2:0], raw_n};
  end

  assign sync_n = sff_q[SYNC_STAGES-1];
  assign differ = sync_n ^ stab_q;

  // Next state: count edges of disagreement, accept on the last one
  always_comb begin
    cnt_d  = cnt_q;
    stab_d = stab_q;
    if (!differ) begin
      cnt_d = '0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_d  = '0;
      stab_d = sync_n;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      stab_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      stab_q <= stab_d;
    end
  end

  assign stable_n = stab_q;

endmodule

// File: rtl/cblp_alloc_core.sv
// Counts attached cards and computes the level for every connector.
module cblp_alloc_core
  import cblp_pkg::*;
#(
  parameter int NUM_CONN = 8
) (
  input  logic [NUM_CONN-1:0]       present,
  output logic [NUM_CONN-1:0][1:0]  lvl
);

  localparam int CNT_W = $clog2(NUM_CONN + 1);
  localparam logic [CNT_W-1:0] SHARE_LIM = CNT_W'(SHARE_MAX);

  logic [CNT_W-1:0] cards;
  logic [CNT_W-1:0] rank;
  pwr_lvl_e         tier;
  logic             all_share;

  always_comb begin
    cards = '0;
    for (int i = 0; i < NUM_CONN; i++) begin
      cards = cards + CNT_W'(present[i]);
    end
  end

  assign tier      = tier_for_count(int'(cards));
  assign all_share = (cards <= SHARE_LIM);

  // rank = attached connectors below this index; only the first
  // SHARE_MAX of them are granted once the budget is oversubscribed
  always_comb begin
    rank = '0;
    for (int i = 0; i < NUM_CONN; i++) begin
      if (present[i] && (all_share || (rank < SHARE_LIM))) lvl[i] = tier;
      else                                                  lvl[i] = LVL_OFF;
      rank = rank + CNT_W'(present[i]);
    end
  end

endmodule

// File: rtl/cblp_code_reg.sv
// Code register with the standby-only update interlock.
module cblp_code_reg #(
  parameter int NUM_CONN = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ps_on_n,
  input  logic                      rails_good,
  input  logic [NUM_CONN-1:0][1:0]  lvl_next,
  output logic [NUM_CONN-1:0][1:0]  code
);

  logic                     upd_en;
  logic [NUM_CONN-1:0][1:0] code_q, code_d;

  assign upd_en = ps_on_n & ~rails_good;

  always_comb begin
    code_d = code_q;
    if (upd_en) code_d = lvl_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  assign code = code_q;

endmodule

// File: rtl/cblp_alloc.sv
module cblp_alloc #(
  parameter int NUM_CONN    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CONN-1:0]   pres_n,
  input  logic                  ps_on_n,
  input  logic                  rails_good,
  output logic [2*NUM_CONN-1:0] sense_code
);

  logic [1:0]               rst_ff;
  logic                     rst_sync_n;
  logic [NUM_CONN-1:0]      pres_sync_n;
  logic [NUM_CONN-1:0]      pres_stable_n;
  logic [NUM_CONN-1:0][1:0] lvl_next;
  logic [NUM_CONN-1:0][1:0] code;

  // Reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= '0;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_sync_n = rst_ff[1];

  for (genvar g = 0; g < NUM_CONN; g++) begin : g_conn
    cblp_deb #(
      .SYNC_STAGES (SYNC_STAGES),
      .DEB_CYCLES  (DEB_CYCLES)
    ) u_deb (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .raw_n    (pres_n[g]),
      .sync_n   (pres_sync_n[g]),
      .stable_n (pres_stable_n[g])
    );
  end

  cblp_alloc_core #(.NUM_CONN(NUM_CONN)) u_core (
    .present (~pres_stable_n),
    .lvl     (lvl_next)
  );

  cblp_code_reg #(.NUM_CONN(NUM_CONN)) u_code (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ps_on_n    (ps_on_n),
    .rails_good (rails_good),
    .lvl_next   (lvl_next),
    .code       (code)
  );

  assign sense_code = code;

endmodule

// File: rtl/cblp_alloc_chk.sv
module cblp_alloc_chk #(
  parameter int NUM_CONN = 8
) (
  input logic                  clk,
  input logic                  rst_sync_n,
  input logic                  ps_on_n,
  input logic                  rails_good,
  input logic [NUM_CONN-1:0]   pres_sync_n,
  input logic [NUM_CONN-1:0]   pres_stable_n,
  input logic [2*NUM_CONN-1:0] sense_code
);

  logic [NUM_CONN-1:0] is_full, is_half, is_quarter, is_on;

  always_comb begin
    for (int i = 0; i < NUM_CONN; i++) begin
      is_full[i]    = (sense_code[2*i +: 2] == 2'b11);
      is_half[i]    = (sense_code[2*i +: 2] == 2'b10);
      is_quarter[i] = (sense_code[2*i +: 2] == 2'b01);
      is_on[i]      = (sense_code[2*i +: 2] != 2'b00);
    end
  end

  AST_FROZEN_OUTSIDE_STANDBY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ps_on_n || rails_good) |=> $stable(sense_code)); // R9

  AST_SINGLE_FULL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(is_full)); // R3

  AST_FULL_ALONE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($countones(is_full) == 1) |-> ($countones(is_on) == 1)); // R3

  AST_HALF_PAIR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($countones(is_half) <= 2)); // R4

  AST_QUARTER_CAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($countones(is_quarter) <= 4)); // R6

  for (genvar i = 0; i < NUM_CONN; i++) begin : g_chk
    AST_EMPTY_OPEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (ps_on_n && !rails_good && pres_stable_n[i]) |=> (sense_code[2*i +: 2] == 2'b00)); // R2

    AST_DEB_NEEDS_DISAGREE: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (pres_stable_n[i] != $past(pres_stable_n[i])) |->
        ($past(pres_sync_n[i]) != $past(pres_stable_n[i]))); // R7
  end

endmodule

bind cblp_alloc cblp_alloc_chk #(.NUM_CONN(NUM_CONN)) u_chk (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .ps_on_n       (ps_on_n),
  .rails_good    (rails_good),
  .pres_sync_n   (pres_sync_n),
  .pres_stable_n (pres_stable_n),
  .sense_code    (sense_code)
);

// File: tb/cblp_alloc_tb.sv
module cblp_alloc_tb;

  logic        clk;
  logic        rst_n;
  logic [7:0]  pres_n;
  logic        ps_on_n;
  logic        rails_good;
  logic [15:0] sense_code;

  int total = 0;
  int bad   = 0;

  cblp_alloc u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .pres_n     (pres_n),
    .ps_on_n    (ps_on_n),
    .rails_good (rails_good),
    .sense_code (sense_code)
  );

  initial clk = 1'b0;
  always #10ns clk = ~clk;   // 50 MHz

  // {pres_n, expected sense_code}; connector i code at bits [2i+1:2i]
  localparam logic [23:0] VEC_TBL [0:9] = '{
    {8'hFF, 16'h0000},   // none attached
    {8'hFE, 16'h0003},   // conn0 alone: 600 W
    {8'h7F, 16'hC000},   // conn7 alone: 600 W
    {8'hDD, 16'h0808},   // conn1, conn5: 300 W each
    {8'hB6, 16'h1041},   // conn0,3,6: 150 W each
    {8'hC3, 16'h0550},   // conn2..5: 150 W each
    {8'hE0, 16'h0055},   // conn0..4: conn4 dropped
    {8'h29, 16'h1114},   // conn1,2,4,6,7: conn7 dropped
    {8'h00, 16'h0055},   // all eight: conn0..3 granted
    {8'h03, 16'h0550}    // conn2..7: conn2..5 granted
  };

  function automatic string vtag(input int v);
    case (v)
      0:       return "R2";
      1, 2:    return "R3";
      3:       return "R4";
      4, 5:    return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: sense_code=%h expected=%h", req, got, exp);
    end
  endtask

  initial begin
    tick(100000);
    bad++;
    $display("FAIL watchdog: run did not finish, got=hung expected=done");
    $display("test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    pres_n     = 8'hFF;
    ps_on_n    = 1'b1;
    rails_good = 1'b0;
    tick(3);
    chk("R1 in reset", sense_code, 16'h0000);
    rst_n = 1'b1;
    tick(30);
    chk("R1 after reset", sense_code, 16'h0000);

    // Table walk in standby
    for (int v = 0; v < 10; v++) begin
      pres_n = VEC_TBL[v][23:16];
      tick(25);
      chk(vtag(v), sense_code, VEC_TBL[v][15:0]);
    end

    // R8 latency from settled all-empty state
    pres_n = 8'hFF;
    tick(25);
    pres_n = 8'hFE;          // applied before edge 0
    tick(18);                // edges 0..17 passed
    chk("R8 edge17", sense_code, 16'h0000);
    tick(1);                 // edge 18 passed
    chk("R8 edge18", sense_code, 16'h0003);

    // R7 glitch of 15 cycles on conn1 is ignored
    pres_n = 8'hFC;
    tick(15);
    pres_n = 8'hFE;
    tick(40);
    chk("R7 glitch", sense_code, 16'h0003);

    // R9 freeze with request asserted
    ps_on_n = 1'b0;
    tick(2);
    pres_n = 8'hFC;
    tick(30);
    chk("R9 ps_on", sense_code, 16'h0003);
    // R9 freeze with rails still good after request released
    rails_good = 1'b1;
    tick(2);
    ps_on_n = 1'b1;
    tick(5);
    chk("R9 rails_good", sense_code, 16'h0003);
    // R10 resume on the next edge of standby
    rails_good = 1'b0;
    tick(1);
    chk("R10 resume", sense_code, 16'h000A);

    // R1 reset in mid-operation clears at once
    @(posedge clk);
    #2ns rst_n = 1'b0;
    #2ns chk("R1 async", sense_code, 16'h0000);
    tick(2);
    rst_n = 1'b1;
    tick(2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule